// File: doc/BRIEF.md
# Loaded Program Image Validator

This block decides whether a program image that already sits in RAM may be started. On a start request it walks a configurable code window one byte at a time over a single-outstanding-read memory port. It adds the bytes into a 16-bit running sum that wraps. It then reads a small header at a fixed base address. That header holds a stored checksum, a mode code and the execution address. Only when the computed sum equals the stored checksum, and the mode code is one of the allowed modes, does it fetch the execution address. It then reports success with a one-cycle done pulse.

A second job, sealing, is meant for the moment right after an image has been loaded. It computes the same sum and writes it into the header. It also writes an all-ones first-load flag next to it. The CPU jump, the RAM itself and the loading of the image are outside the block.

Top module: `image_launch_gate`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `mem_rd_en` and `mem_wr_en` are low and `exec_addr` is zero.
- R2: Both jobs read every byte address from `SUM_LO` up to but not including `SUM_HI` exactly once, in ascending order. Each read is a one-cycle `mem_rd_en`, and the next read is issued only after `mem_rvalid` has returned the previous byte. The sum is the byte total modulo 2^16.
- R3: The header words are big-endian. The checksum is at `HDR_BASE+2` (high byte) and `HDR_BASE+3`, and the execution address is at `HDR_BASE+0` (high byte) and `HDR_BASE+1`. The mode code is the byte at `HDR_BASE+MODE_OFS`. A check passes only if the sum equals the stored checksum and the mode code indexes a set bit of `MODE_MASK`.
- R4: When a check passes, `done` pulses with `pass` high and `exec_addr` equal to the stored execution address.
- R5: When a check fails, `done` pulses with `pass` low and `exec_addr` zero, and neither execution address byte is read.
- R6: A seal job writes the sum high byte to `HDR_BASE+2` and the low byte to `HDR_BASE+3`. It writes 0xFF to `HDR_BASE+4` and `HDR_BASE+5`, in that order, and then pulses `done` with `pass` high and `exec_addr` zero.
- R7: `busy` rises in the cycle after an accepted start and stays high until the cycle in which `done` is high. In that cycle `busy` is low. `done` lasts one cycle.
- R8: Start requests that arrive while `busy` is high are ignored.
- R9: If `start_check` and `start_seal` are high in the same idle cycle, the check job runs and nothing is written.
- R10: A mode code at or beyond the width of `MODE_MASK` fails the check even when the checksum matches.
- R11: `pass` and `exec_addr` keep their values after `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_check | input | 1 | Begin a validation job |
| start_seal | input | 1 | Begin a seal (sum write-back) job |
| mem_rd_en | output | 1 | One-cycle byte read request |
| mem_wr_en | output | 1 | One-cycle byte write |
| mem_addr | output | ADDR_W | Byte address for the read or write |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read data return |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle job completion pulse |
| pass | output | 1 | Result of the last job |
| exec_addr | output | 16 | Execution address, nonzero only after a passing check |

## Verification
The assertions assume the memory answers at most once per read request, and only while a read is outstanding. They also assume the port never returns data unprompted. The bench memory model honours this. It holds each request in a single pending slot and replies once after a random latency of one to three cycles. Start requests are driven only on falling edges. A stray start is injected mid-job on purpose to show that it is ignored, rather than to break the single-outstanding-read contract.

// File: rtl/ivl_pkg.sv
package ivl_pkg;
    localparam int BYTE_W = 8;
    localparam int CSUM_W = 16;

    // header byte offsets from the base address
    localparam int HDR_EXEC_OFS = 0;
    localparam int HDR_CSUM_OFS = 2;
    localparam int HDR_FLAG_OFS = 4;

    localparam int STEP_W = 3;
    // header read steps
    localparam logic [STEP_W-1:0] RS_CSUM_HI = 3'd0;
    localparam logic [STEP_W-1:0] RS_CSUM_LO = 3'd1;
    localparam logic [STEP_W-1:0] RS_MODE    = 3'd2;
    localparam logic [STEP_W-1:0] RS_EXEC_HI = 3'd3;
    localparam logic [STEP_W-1:0] RS_EXEC_LO = 3'd4;
    // seal write steps
    localparam logic [STEP_W-1:0] WS_LAST    = 3'd3;

    localparam logic [BYTE_W-1:0] FLAG_TRUE_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUM_REQ,
        ST_SUM_WAIT,
        ST_HDR_REQ,
        ST_HDR_WAIT,
        ST_DECIDE,
        ST_SEAL_WR
    } ivl_state_e;

    typedef enum logic {
        JOB_CHECK,
        JOB_SEAL
    } ivl_job_e;
endpackage

// File: rtl/ivl_byte_sum.sv
module ivl_byte_sum
    import ivl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add_en,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CSUM_W-1:0] sum_out
);
    logic [CSUM_W-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clear)
            sum_d = '0;
        else if (add_en)
            sum_d = sum_q + CSUM_W'(byte_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum_out = sum_q;

    // R2
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sum_out == '0));
endmodule

// File: rtl/ivl_mode_check.sv
module ivl_mode_check
    import ivl_pkg::*;
#(
    parameter int                  MASK_W    = 16,
    parameter logic [MASK_W-1:0]   MODE_MASK = 16'h0006
) (
    input  logic [BYTE_W-1:0] mode_in,
    output logic              mode_ok
);
    localparam int IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;

    generate
        if (MASK_W >= (1 << BYTE_W)) begin : g_full
            // every byte value has its own mask bit
            assign mode_ok = MODE_MASK[mode_in[IDX_W-1:0]];
        end else begin : g_part
            logic in_range;
            assign in_range = (int'(mode_in) < MASK_W);
            assign mode_ok  = in_range && MODE_MASK[mode_in[IDX_W-1:0]];
        end
    endgenerate
endmodule

// File: rtl/ivl_seq.sv
module ivl_seq
    import ivl_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SUM_LO   = 16'h3B00,
    parameter logic [ADDR_W-1:0] SUM_HI   = 16'h4B00,
    parameter logic [ADDR_W-1:0] HDR_BASE = 16'h1000,
    parameter int                MODE_OFS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_check,
    input  logic              start_seal,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              acc_clear,
    output logic              acc_add,
    input  logic [CSUM_W-1:0] sum_in,
    output logic [BYTE_W-1:0] mode_code,
    input  logic              mode_ok,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [CSUM_W-1:0] exec_addr
);
    localparam logic [ADDR_W-1:0] SUM_LAST = SUM_HI - ADDR_W'(1);

    typedef struct packed {
        ivl_state_e          st;
        ivl_job_e            job;
        logic [ADDR_W-1:0]   ptr;
        logic [STEP_W-1:0]   step;
        logic [CSUM_W-1:0]   csum;
        logic [BYTE_W-1:0]   mode;
        logic [CSUM_W-1:0]   ea;
        logic                done;
        logic                pass;
    } seq_t;

    seq_t r_d, r_q;

    function automatic logic [ADDR_W-1:0] hdr_rd_addr(input logic [STEP_W-1:0] s);
        case (s)
            RS_CSUM_HI: hdr_rd_addr = HDR_BASE + ADDR_W'(HDR_CSUM_OFS);
            RS_CSUM_LO: hdr_rd_addr = HDR_BASE + ADDR_W'(HDR_CSUM_OFS + 1);
            RS_MODE:    hdr_rd_addr = HDR_BASE + ADDR_W'(MODE_OFS);
            RS_EXEC_HI: hdr_rd_addr = HDR_BASE + ADDR_W'(HDR_EXEC_OFS);
            default:    hdr_rd_addr = HDR_BASE + ADDR_W'(HDR_EXEC_OFS + 1);
        endcase
    endfunction

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        acc_clear = 1'b0;
        acc_add   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_check || start_seal) begin
                    r_d.job   = start_check ? JOB_CHECK : JOB_SEAL;
                    r_d.ptr   = SUM_LO;
                    r_d.step  = '0;
                    r_d.pass  = 1'b0;
                    r_d.ea    = '0;
                    r_d.csum  = '0;
                    r_d.mode  = '0;
                    acc_clear = 1'b1;
                    r_d.st    = ST_SUM_REQ;
                end
            end
            ST_SUM_REQ: r_d.st = ST_SUM_WAIT;
            ST_SUM_WAIT: begin
                if (rd_valid) begin
                    acc_add  = 1'b1;
                    r_d.ptr  = r_q.ptr + ADDR_W'(1);
                    r_d.step = '0;
                    if (r_q.ptr == SUM_LAST)
                        r_d.st = (r_q.job == JOB_CHECK) ? ST_HDR_REQ : ST_SEAL_WR;
                    else
                        r_d.st = ST_SUM_REQ;
                end
            end
            ST_HDR_REQ: r_d.st = ST_HDR_WAIT;
            ST_HDR_WAIT: begin
                if (rd_valid) begin
                    case (r_q.step)
                        RS_CSUM_HI: r_d.csum[CSUM_W-1:BYTE_W] = rd_data;
                        RS_CSUM_LO: r_d.csum[BYTE_W-1:0]      = rd_data;
                        RS_MODE:    r_d.mode                  = rd_data;
                        RS_EXEC_HI: r_d.ea[CSUM_W-1:BYTE_W]   = rd_data;
                        default:    r_d.ea[BYTE_W-1:0]        = rd_data;
                    endcase
                    if (r_q.step == RS_MODE) begin
                        r_d.st = ST_DECIDE;
                    end else if (r_q.step == RS_EXEC_LO) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.pass = 1'b1;
                    end else begin
                        r_d.step = r_q.step + STEP_W'(1);
                        r_d.st   = ST_HDR_REQ;
                    end
                end
            end
            ST_DECIDE: begin
                if ((sum_in == r_q.csum) && mode_ok) begin
                    r_d.step = RS_EXEC_HI;
                    r_d.st   = ST_HDR_REQ;
                end else begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.pass = 1'b0;
                    r_d.ea   = '0;
                end
            end
            ST_SEAL_WR: begin
                if (r_q.step == WS_LAST) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.pass = 1'b1;
                end else begin
                    r_d.step = r_q.step + STEP_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.job  <= JOB_CHECK;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_en   = (r_q.st == ST_SUM_REQ) || (r_q.st == ST_HDR_REQ);
        rd_addr = (r_q.st == ST_SUM_REQ) ? r_q.ptr : hdr_rd_addr(r_q.step);
        wr_en   = (r_q.st == ST_SEAL_WR);
        wr_addr = HDR_BASE + ADDR_W'(HDR_CSUM_OFS) + ADDR_W'(r_q.step);
        case (r_q.step)
            3'd0:    wr_data = sum_in[CSUM_W-1:BYTE_W];
            3'd1:    wr_data = sum_in[BYTE_W-1:0];
            default: wr_data = FLAG_TRUE_BYTE;
        endcase
    end

    assign mode_code = r_q.mode;
    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign pass      = r_q.pass;
    assign exec_addr = r_q.ea;

    // R2
    sum_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && r_q.st == ST_SUM_REQ) |-> (rd_addr >= SUM_LO && rd_addr < SUM_HI));
    // R2
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);
    // R2
    rvalid_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (r_q.st == ST_SUM_WAIT || r_q.st == ST_HDR_WAIT));
    // R6
    rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));
    // R5
    fail_no_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> (exec_addr == '0));
    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !start_check && !start_seal) |=> ($stable(pass) && $stable(exec_addr)));
endmodule

// File: rtl/image_launch_gate.sv
module image_launch_gate
    import ivl_pkg::*;
#(
    parameter int                  ADDR_W      = 16,
    parameter logic [ADDR_W-1:0]   SUM_LO      = 16'h3B00,
    parameter logic [ADDR_W-1:0]   SUM_HI      = 16'h4B00,
    parameter logic [ADDR_W-1:0]   HDR_BASE    = 16'h1000,
    parameter int                  MODE_OFS    = 6,
    parameter int                  MODE_MASK_W = 16,
    parameter logic [MODE_MASK_W-1:0] MODE_MASK = 16'h0006
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_check,
    input  logic              start_seal,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_rvalid,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [15:0]       exec_addr
);
    logic              acc_clear, acc_add;
    logic [CSUM_W-1:0] sum_val;
    logic [BYTE_W-1:0] mode_code;
    logic              mode_ok;
    logic [ADDR_W-1:0] rd_addr, wr_addr;

    ivl_byte_sum u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (acc_clear),
        .add_en  (acc_add),
        .byte_in (mem_rdata),
        .sum_out (sum_val)
    );

    ivl_mode_check #(
        .MASK_W    (MODE_MASK_W),
        .MODE_MASK (MODE_MASK)
    ) u_mode (
        .mode_in (mode_code),
        .mode_ok (mode_ok)
    );

    ivl_seq #(
        .ADDR_W   (ADDR_W),
        .SUM_LO   (SUM_LO),
        .SUM_HI   (SUM_HI),
        .HDR_BASE (HDR_BASE),
        .MODE_OFS (MODE_OFS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_check (start_check),
        .start_seal  (start_seal),
        .rd_en       (mem_rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (mem_rdata),
        .rd_valid    (mem_rvalid),
        .wr_en       (mem_wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (mem_wdata),
        .acc_clear   (acc_clear),
        .acc_add     (acc_add),
        .sum_in      (sum_val),
        .mode_code   (mode_code),
        .mode_ok     (mode_ok),
        .busy        (busy),
        .done        (done),
        .pass        (pass),
        .exec_addr   (exec_addr)
    );

    assign mem_addr = mem_wr_en ? wr_addr : rd_addr;
endmodule

// File: tb/tb_image_launch_gate.sv
`timescale 1ns/1ps
module tb_image_launch_gate;
    localparam logic [15:0] LO   = 16'h3B00;
    localparam logic [15:0] HI   = 16'h3D00;
    localparam int          NB   = 512;
    localparam logic [15:0] BASE = 16'h1000;
    localparam logic [15:0] MASK = 16'h00A6; // modes 1,2,5,7

    logic clk = 0, rst_n = 0;
    logic start_check = 0, start_seal = 0;
    logic mem_rd_en, mem_wr_en, mem_rvalid = 0;
    logic [15:0] mem_addr, exec_addr;
    logic [7:0] mem_wdata, mem_rdata = 0;
    logic busy, done, pass;

    always #5 clk = ~clk;

    image_launch_gate #(.SUM_LO(LO), .SUM_HI(HI), .HDR_BASE(BASE),
                        .MODE_OFS(6), .MODE_MASK_W(16), .MODE_MASK(MASK)) dut (
        .clk(clk), .rst_n(rst_n), .start_check(start_check), .start_seal(start_seal),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .busy(busy), .done(done), .pass(pass), .exec_addr(exec_addr));

    logic [7:0] code_mem [0:NB-1];
    logic [7:0] hdr_mem  [0:15];
    int n_cmp = 0, n_bad = 0;
    int sum_reads, order_err, ea_reads, wr_cnt, bad_acc, cyc = 0;
    logic [15:0] next_sum_addr;
    bit pend = 0; int pcnt = 0; logic [15:0] paddr;

    function automatic logic [7:0] rd_byte(input logic [15:0] a);
        if (a >= LO && a < HI) return code_mem[a - LO];
        if (a >= BASE && a < BASE + 16) return hdr_mem[a - BASE];
        return 8'hEE;
    endfunction

    function automatic logic [15:0] exp_sum();
        logic [15:0] s = 0;
        for (int i = 0; i < NB; i++) s = s + 16'(code_mem[i]);
        return s;
    endfunction

    function automatic bit mode_valid(input logic [7:0] m);
        return (m < 16) && MASK[m[3:0]];
    endfunction

    // memory model: one pending read, latency 1..3 cycles
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_rd_en) begin
            int l;
            l = int'($urandom % 3);
            if (mem_addr >= LO && mem_addr < HI) begin
                if (mem_addr != next_sum_addr) order_err++;
                next_sum_addr = mem_addr + 1;
                sum_reads++;
            end else if (mem_addr == BASE || mem_addr == BASE + 1) ea_reads++;
            else if (!(mem_addr >= BASE && mem_addr < BASE + 16)) bad_acc++;
            if (l == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= rd_byte(mem_addr);
            end else begin
                pend = 1; pcnt = l; paddr = mem_addr;
            end
        end else if (pend) begin
            pcnt--;
            if (pcnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= rd_byte(paddr);
                pend = 0;
            end
        end
        if (mem_wr_en) begin
            wr_cnt++;
            if (mem_addr >= BASE && mem_addr < BASE + 16) hdr_mem[mem_addr - BASE] = mem_wdata;
            else bad_acc++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill_code(input int kind);
        for (int i = 0; i < NB; i++)
            code_mem[i] = (kind == 1) ? 8'hFF : 8'($urandom);
    endtask

    task automatic set_hdr(input logic [15:0] ea, input logic [15:0] ck, input logic [7:0] m);
        for (int i = 0; i < 16; i++) hdr_mem[i] = 8'h00;
        hdr_mem[0] = ea[15:8]; hdr_mem[1] = ea[7:0];
        hdr_mem[2] = ck[15:8]; hdr_mem[3] = ck[7:0];
        hdr_mem[6] = m;
    endtask

    logic got_pass; logic [15:0] got_ea;

    // run one job; stray = pulse start_seal mid-job
    task automatic run(input bit chk, input bit seal, input bit stray);
        int t;
        @(negedge clk);
        sum_reads = 0; order_err = 0; ea_reads = 0; wr_cnt = 0; bad_acc = 0;
        next_sum_addr = LO;
        start_check = chk; start_seal = seal;
        @(negedge clk);
        start_check = 0; start_seal = 0;
        check(busy === 1'b1, "R7", "busy after start", busy, 1);
        if (stray) begin
            repeat (20) @(negedge clk);
            start_seal = 1; start_check = 1;
            @(negedge clk);
            start_seal = 0; start_check = 0;
        end
        t = 0;
        while (done !== 1'b1 && t < 20000) begin @(negedge clk); t++; end
        check(t < 20000, "R7", "done reached", t, 0);
        check(busy === 1'b0, "R7", "busy low with done", busy, 0);
        got_pass = pass; got_ea = exec_addr;
        @(negedge clk);
        check(done === 1'b0, "R7", "done one cycle", done, 0);
        check(sum_reads == NB && order_err == 0 && bad_acc == 0, "R2",
              "window read count", sum_reads, NB);
    endtask

    task automatic do_check(input logic [15:0] ea, input bit exp_p, input bit stray);
        run(1, stray ? 1'b0 : 1'b0, stray);
        check(got_pass == exp_p, exp_p ? "R4" : "R5", "pass", got_pass, exp_p);
        check(got_ea == (exp_p ? ea : 16'h0), exp_p ? "R4" : "R5", "exec_addr",
              got_ea, exp_p ? ea : 16'h0);
        check(ea_reads == (exp_p ? 2 : 0), "R5", "exec reads", ea_reads, exp_p ? 2 : 0);
        check(wr_cnt == 0, stray ? "R8" : "R3", "no writes on check", wr_cnt, 0);
    endtask

    task automatic do_seal();
        logic [15:0] s;
        s = exp_sum();
        run(0, 1, 0);
        check(got_pass == 1 && got_ea == 0, "R6", "seal result", {got_pass, got_ea}, 17'h10000);
        check(wr_cnt == 4, "R6", "seal write count", wr_cnt, 4);
        check({hdr_mem[2], hdr_mem[3]} == s, "R6", "sealed sum", {hdr_mem[2], hdr_mem[3]}, s);
        check(hdr_mem[4] == 8'hFF && hdr_mem[5] == 8'hFF, "R6", "first-load flag",
              {hdr_mem[4], hdr_mem[5]}, 16'hFFFF);
    endtask

    initial begin
        while (1) begin
            @(posedge clk); cyc++;
            if (cyc > 150000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] good_modes [0:3];
        logic [7:0] bad_modes  [0:3];
        good_modes = '{8'd1, 8'd2, 8'd5, 8'd7};
        bad_modes  = '{8'd0, 8'd3, 8'd6, 8'd12};
        void'($urandom(32'h5eed));
        for (int i = 0; i < 16; i++) hdr_mem[i] = 0;
        repeat (3) @(negedge clk);
        check(busy === 0 && done === 0 && pass === 0 && exec_addr === 0 &&
              mem_rd_en === 0 && mem_wr_en === 0, "R1", "reset state",
              {busy, done, pass, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1;

        // R3 R4: matching sum and valid mode
        fill_code(0); set_hdr(16'hABCD, exp_sum(), 8'd5);
        do_check(16'hABCD, 1, 0);
        // R11: result held after done
        repeat (4) @(negedge clk);
        check(pass === 1'b1 && exec_addr === 16'hABCD, "R11", "result held",
              exec_addr, 16'hABCD);
        // R5: checksum off by one
        set_hdr(16'h1234, exp_sum() + 16'd1, 8'd5);
        do_check(16'h1234, 0, 0);
        // R3: mode in range but not allowed
        set_hdr(16'h1234, exp_sum(), 8'd3);
        do_check(16'h1234, 0, 0);
        // R10: mode beyond mask width
        set_hdr(16'h1234, exp_sum(), 8'h21);
        do_check(16'h1234, 0, 0);
        set_hdr(16'h1234, exp_sum(), 8'd16);
        do_check(16'h1234, 0, 0);
        // R2: all-ones bytes force wrap of the 16-bit sum (512*255 mod 2^16 = 0xFE00)
        fill_code(1);
        check(exp_sum() == 16'hFE00, "R2", "wrap reference", exp_sum(), 16'hFE00);
        set_hdr(16'h0F0F, 16'hFE00, 8'd7);
        do_check(16'h0F0F, 1, 0);
        // R6: seal, then the sealed image validates
        fill_code(0); set_hdr(16'h2468, 16'h0000, 8'd2);
        do_seal();
        check(hdr_mem[0] == 8'h24 && hdr_mem[6] == 8'd2, "R6", "other header bytes kept",
              {hdr_mem[0], hdr_mem[6]}, 16'h2402);
        do_check(16'h2468, 1, 0);
        // R8: starts during a job are ignored
        fill_code(0); set_hdr(16'h7777, exp_sum(), 8'd1);
        do_check(16'h7777, 1, 1);
        // R9: both starts together run the check
        set_hdr(16'h5151, exp_sum(), 8'd2);
        run(1, 1, 0);
        check(wr_cnt == 0 && got_pass == 1 && got_ea == 16'h5151, "R9", "check wins",
              wr_cnt, 0);

        // random mix
        for (int it = 0; it < 10; it++) begin
            int kind;
            logic [15:0] ea;
            logic [7:0] m;
            kind = int'($urandom % 4);
            ea = 16'($urandom);
            fill_code(0);
            case (kind)
                0: begin
                    m = good_modes[$urandom % 4];
                    set_hdr(ea, exp_sum(), m);
                    do_check(ea, mode_valid(m), 0);
                end
                1: begin
                    m = good_modes[$urandom % 4];
                    set_hdr(ea, exp_sum() ^ 16'(1 << ($urandom % 16)), m);
                    do_check(ea, 0, 0);
                end
                2: begin
                    m = bad_modes[$urandom % 4];
                    set_hdr(ea, exp_sum(), m);
                    do_check(ea, mode_valid(m), 0);
                end
                default: begin
                    m = good_modes[$urandom % 4];
                    set_hdr(ea, 16'h0000, m);
                    do_seal();
                    do_check(ea, 1, 0);
                end
            endcase
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule